// File: doc/BRIEF.md
# Edge-Capture Input Port Controller

This block watches two parallel input ports. For each port it records every rising and every falling transition of each pin in two sticky registers. It also keeps a data register that is loaded in one of two ways. The first is on every clock, from the synchronised pins. The second is on a falling transition of a per-port external trigger input. A three-bit command register for each port chooses the capture source and the reporting options.

A small register file is reached over a simple strobe interface: write enable, read enable, a 3-bit address and a data word. Reads are combinational. The command, edge and data addresses are banked: bit 4 of the global control register selects port A (0) or port B (1). Reported edge activity drives a per-port local interrupt line. A system interrupt line follows those local lines only when bit 5 of the global control register is set. A trigger-captured sample raises a data-available flag, and reading that port's data clears the flag.

Top module: `edge_capture_port`

## Requirements
- R1: After reset, every command register, both edge registers of each port, both data-available flags, both local interrupts and the system interrupt are 0.
- R2: Global control (address 0) stores bit 4 as the bank select and bit 5 as the interrupt enable, and reads back only those two bits. Addresses 1 (command), 2 (rising edges), 3 (falling edges) and 6 (data) act on port A when the select is 0 and on port B when it is 1.
- R3: A command write stores wdata[2:0]: bit 0 is the edge-report enable, bit 1 selects external-trigger capture, and bit 2 is the data-available enable. A read returns those three bits with all higher bits zero.
- R4: A 0-to-1 change on a pin sets that pin's bit in the rising-edge register, and a 1-to-0 change sets its bit in the falling-edge register. The bit is set on the third clock edge after the change and stays set.
- R5: Writing a mask to address 2 or 3 clears the bits where the mask is 1. A new edge captured in the same cycle as the clear keeps its bit set.
- R6: A port's local interrupt, also read as bit p (A = 0, B = 1) of address 4, is 1 exactly when its edge-report enable is 1 and either of its edge registers is nonzero.
- R7: The system interrupt is 1 only when control bit 5 is 1 and at least one local interrupt is 1.
- R8: With command bit 1 at 0, the data register (address 6) follows the synchronised pins every clock.
- R9: With command bit 1 at 1, the data register loads the synchronised pins only on a falling transition of the port's trigger, seen three clock edges after that transition. Otherwise it holds.
- R10: A trigger capture with command bits 1 and 2 both at 1 sets the port's data-available flag, which is read as bit p of address 5. Without bit 2 the capture still occurs but the flag stays 0.
- R11: A read of address 6 clears the data-available flag of the selected port only. A trigger capture in the same cycle as that read keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for read side effects) |
| addr | input | 3 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Combinational read data for addr |
| pin_a | input | W | Port A input pins |
| pin_b | input | W | Port B input pins |
| ext | input | 2 | External triggers, bit 0 port A, bit 1 port B |
| intr | output | 2 | Local edge interrupts, bit 0 port A, bit 1 port B |
| irq | output | 1 | Gated system interrupt |

## Verification
An edge can be captured in the same cycle as a write-one-to-clear of the same bit. The bench drives a pin back high after its earlier rising edge has been recorded. It times the clearing write so that the write strobe is sampled on the same clock edge that captures the new rising edge. The rising-edge register must then read back with the bit still set. A second clear with no edge pending must then return the bit to zero.

// File: rtl/ecp_pkg.sv
// Package: shared register addresses, control bit positions and the
// per-port command layout for the edge-capture port controller.
package ecp_pkg;

    localparam int NPORT        = 2;
    localparam int CTRL_SEL_BIT = 4;
    localparam int CTRL_IRQ_BIT = 5;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CMD   = 3'd1,
        A_RISE  = 3'd2,
        A_FALL  = 3'd3,
        A_ESTAT = 3'd4,
        A_DSTAT = 3'd5,
        A_DATA  = 3'd6
    } reg_addr_e;

    // Command register, bit 0 at the bottom.
    typedef struct packed {
        logic dav_en;     // bit 2
        logic ext_mode;   // bit 1
        logic edge_en;    // bit 0
    } cmd_t;

endpackage

// File: rtl/ecp_sync.sv
// Module: ecp_sync
// Two-flop synchroniser for an N-bit bundle of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module ecp_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ecp_port.sv
// Module: ecp_port
// One input port: command register, sticky rising/falling edge registers
// with write-one-to-clear, data register in clocked or triggered mode,
// and the data-available flag. Assumes the write/read strobes are already
// decoded for this port by the top level.
module ecp_port
    import ecp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic         ext,
    input  logic         cmd_we,
    input  logic [2:0]   cmd_wd,
    input  logic         rise_clr_we,
    input  logic         fall_clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic         data_rd,
    output logic [2:0]   cmd_q,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q,
    output logic [W-1:0] data_q,
    output logic         dav_q,
    output logic         intr
);
    localparam int SW = W + 1;

    logic [SW-1:0] sy;
    logic [SW-1:0] sy_d;
    logic [W-1:0]  pin_rise;
    logic [W-1:0]  pin_fall;
    logic          trig_fall;
    logic          dav_set;
    cmd_t          cmd;

    ecp_sync #(.N(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext, pin}),
        .q     (sy)
    );

    assign cmd       = cmd_t'(cmd_q);
    assign pin_rise  = sy[W-1:0] & ~sy_d[W-1:0];
    assign pin_fall  = ~sy[W-1:0] & sy_d[W-1:0];
    assign trig_fall = ~sy[W] & sy_d[W];
    assign dav_set   = trig_fall & cmd.ext_mode & cmd.dav_en;
    assign intr      = cmd.edge_en & ((|rise_q) | (|fall_q));

    // Delayed copy of the synchronised inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sy_d <= '0;
        else        sy_d <= sy;
    end

    // Command register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= cmd_wd;
    end

    // Sticky edge registers: clear by mask, new edges win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= (rise_q & ~(rise_clr_we ? clr_mask : '0)) | pin_rise;
            fall_q <= (fall_q & ~(fall_clr_we ? clr_mask : '0)) | pin_fall;
        end
    end

    // Data register: follow pins, or load on trigger falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                         data_q <= '0;
        else if (!cmd.ext_mode || trig_fall) data_q <= sy[W-1:0];
    end

    // Data-available flag: set by trigger capture, cleared by data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       dav_q <= 1'b0;
        else if (dav_set) dav_q <= 1'b1;
        else if (data_rd) dav_q <= 1'b0;
    end
endmodule

// File: rtl/edge_capture_port.sv
// Module: edge_capture_port
// Top level: global control register (bank select, interrupt enable),
// address decode with banking onto two ecp_port instances, combinational
// read mux and gated system interrupt. Assumes W >= 6 so that the control
// bits fit the data word.
module edge_capture_port
    import ecp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic [1:0]   ext,
    output logic [1:0]   intr,
    output logic         irq
);
    localparam int NP = NPORT;

    logic                 bank_sel;
    logic                 irq_en;
    logic [NP-1:0][W-1:0] pins;
    logic [NP-1:0][2:0]   cmd_q;
    logic [NP-1:0][W-1:0] rise_q;
    logic [NP-1:0][W-1:0] fall_q;
    logic [NP-1:0][W-1:0] data_q;
    logic [NP-1:0]        dav_q;

    assign pins[0] = pin_a;
    assign pins[1] = pin_b;

    // Global control register: bank select and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel <= 1'b0;
            irq_en   <= 1'b0;
        end else if (wr_en && addr == A_CTRL) begin
            bank_sel <= wdata[CTRL_SEL_BIT];
            irq_en   <= wdata[CTRL_IRQ_BIT];
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic hit;
        assign hit = (bank_sel == 1'(p));

        ecp_port #(.W(W)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin         (pins[p]),
            .ext         (ext[p]),
            .cmd_we      (wr_en && hit && addr == A_CMD),
            .cmd_wd      (wdata[2:0]),
            .rise_clr_we (wr_en && hit && addr == A_RISE),
            .fall_clr_we (wr_en && hit && addr == A_FALL),
            .clr_mask    (wdata),
            .data_rd     (rd_en && hit && addr == A_DATA),
            .cmd_q       (cmd_q[p]),
            .rise_q      (rise_q[p]),
            .fall_q      (fall_q[p]),
            .data_q      (data_q[p]),
            .dav_q       (dav_q[p]),
            .intr        (intr[p])
        );
    end

    // Combinational read mux, banked by the select bit.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_SEL_BIT] = bank_sel;
                rdata[CTRL_IRQ_BIT] = irq_en;
            end
            A_CMD:   rdata[2:0]    = cmd_q[bank_sel];
            A_RISE:  rdata         = rise_q[bank_sel];
            A_FALL:  rdata         = fall_q[bank_sel];
            A_ESTAT: rdata[NP-1:0] = intr;
            A_DSTAT: rdata[NP-1:0] = dav_q;
            A_DATA:  rdata         = data_q[bank_sel];
            default: rdata         = '0;
        endcase
    end

    assign irq = irq_en & (|intr);
endmodule

// File: rtl/edge_capture_port_chk.sv
// Module: edge_capture_port_chk
// Assertion checker bound into edge_capture_port. Relates register
// changes to the accesses that may cause them.
module edge_capture_port_chk
    import ecp_pkg::*;
#(
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [2:0]          addr,
    input logic [1:0]          intr,
    input logic                irq,
    input logic                bank_sel,
    input logic [1:0][2:0]     cmd_q,
    input logic [1:0][W-1:0]   rise_q,
    input logic [1:0][W-1:0]   fall_q,
    input logic [1:0]          dav_q
);
    AST_IRQ_NEEDS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|intr)); // R7

    for (genvar p = 0; p < 2; p++) begin : g_chk
        AST_RISE_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (|($past(rise_q[p]) & ~rise_q[p])) |->
            $past(wr_en && addr == A_RISE && bank_sel == 1'(p))); // R5

        AST_FALL_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (|($past(fall_q[p]) & ~fall_q[p])) |->
            $past(wr_en && addr == A_FALL && bank_sel == 1'(p))); // R5

        AST_INTR_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(intr[p]) |->
            $past(wr_en && (addr == A_CMD || addr == A_RISE || addr == A_FALL))); // R6

        AST_DAV_SET_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dav_q[p]) |-> $past(cmd_q[p][1] && cmd_q[p][2])); // R10

        AST_DAV_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dav_q[p]) |->
            $past(rd_en && addr == A_DATA && bank_sel == 1'(p))); // R11
    end
endmodule

bind edge_capture_port edge_capture_port_chk #(.W(W)) u_chk (.*);

// File: tb/edge_capture_port_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, a monitor on the
// falling clock edge pops and compares them against the ports.
module edge_capture_port_tb_top;
    localparam int W = 8;
    localparam int K_RD = 0, K_INTR = 1, K_IRQ = 2;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] pin_a = '0;
    logic [W-1:0] pin_b = '0;
    logic [1:0]   ext = 2'b11;
    logic [1:0]   intr;
    logic         irq;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t sb_q[$];

    edge_capture_port #(.W(W)) dut_i (.*);

    always #2.5 clk = ~clk;

    // Monitor: compare one queued expectation per falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = rdata;
                K_INTR:  act = {6'd0, intr};
                default: act = {7'd0, irq};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        sb_q.push_back('{K_RD, e, tag});
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic sig_chk(input int k, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{k, e, tag});
        @(posedge clk); #1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd_chk(3'd1, 8'h00, "R1 cmd after reset");
        rd_chk(3'd5, 8'h00, "R1 dav status after reset");
        rd_chk(3'd4, 8'h00, "R1 edge status after reset");
        sig_chk(K_INTR, 8'h00, "R1 intr after reset");
        sig_chk(K_IRQ, 8'h00, "R1 irq after reset");
        // R2 and R3 banking and command readback
        wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'h30, "R2 ctrl readback");
        wr(3'd0, 8'h10);
        wr(3'd1, 8'hFD);
        rd_chk(3'd1, 8'h05, "R3 cmd B readback");
        wr(3'd0, 8'h00);
        rd_chk(3'd1, 8'h00, "R2 cmd A untouched");
        // R8 internal capture, R4 rising edges, R6 reporting off
        pin_a = 8'h5A;
        idle(4);
        rd_chk(3'd6, 8'h5A, "R8 data follows pins");
        rd_chk(3'd2, 8'h5A, "R4 rising edges");
        rd_chk(3'd4, 8'h00, "R6 no report when disabled");
        // R6 / R7 interrupt paths
        wr(3'd1, 8'h01);
        rd_chk(3'd4, 8'h01, "R6 edge status A");
        sig_chk(K_INTR, 8'h01, "R6 intr A");
        sig_chk(K_IRQ, 8'h00, "R7 irq gated off");
        wr(3'd0, 8'h20);
        sig_chk(K_IRQ, 8'h01, "R7 irq enabled");
        // R4 falling edges
        pin_a = 8'h18;
        idle(4);
        rd_chk(3'd3, 8'h42, "R4 falling edges");
        // R5 write-one-to-clear
        wr(3'd2, 8'h5A);
        rd_chk(3'd2, 8'h00, "R5 rise cleared");
        wr(3'd3, 8'h40);
        rd_chk(3'd3, 8'h02, "R5 partial fall clear");
        wr(3'd3, 8'h02);
        sig_chk(K_INTR, 8'h00, "R6 intr drops");
        sig_chk(K_IRQ, 8'h00, "R7 irq drops");
        // R5 collision: clear and new edge on the same clock edge
        pin_a = 8'h19;
        idle(4);
        pin_a = 8'h18;
        idle(4);
        @(posedge clk); #1;
        pin_a = 8'h19;
        @(posedge clk);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = 3'd2; wdata = 8'h01;
        @(posedge clk); #1;
        wr_en = 1'b0;
        rd_chk(3'd2, 8'h01, "R5 new edge wins over clear");
        wr(3'd2, 8'h01);
        rd_chk(3'd2, 8'h00, "R5 clear without edge");
        wr(3'd3, 8'h01);
        // R9 / R10 / R11 triggered capture on port A
        wr(3'd1, 8'h06);
        pin_a = 8'h3C;
        idle(4);
        rd_chk(3'd6, 8'h19, "R9 data held without trigger");
        rd_chk(3'd5, 8'h00, "R10 no flag without trigger");
        @(posedge clk); #1;
        ext[0] = 1'b0;
        idle(4);
        rd_chk(3'd5, 8'h01, "R10 flag set by trigger");
        rd_chk(3'd6, 8'h3C, "R9 data latched by trigger");
        rd_chk(3'd5, 8'h00, "R11 flag cleared by read");
        ext[0] = 1'b1;
        idle(4);
        // R10 trigger without flag enable
        wr(3'd1, 8'h02);
        pin_a = 8'h77;
        idle(4);
        ext[0] = 1'b0;
        idle(4);
        rd_chk(3'd5, 8'h00, "R10 flag stays off");
        rd_chk(3'd6, 8'h77, "R9 capture without flag");
        ext[0] = 1'b1;
        idle(4);
        // R11 read of port A does not clear port B flag
        wr(3'd0, 8'h30);
        wr(3'd1, 8'h06);
        pin_b = 8'hA5;
        idle(4);
        ext[1] = 1'b0;
        idle(4);
        wr(3'd0, 8'h20);
        rd_chk(3'd6, 8'h77, "R2 data A while B pending");
        rd_chk(3'd5, 8'h02, "R11 B flag kept");
        wr(3'd0, 8'h30);
        rd_chk(3'd6, 8'hA5, "R9 data B latched");
        rd_chk(3'd5, 8'h00, "R11 B flag cleared");
        idle(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule